// File: doc/BRIEF.md
# Effective Privilege and Page Permission Gate

This block is purely combinational. Each cycle it takes the hart's current privilege mode, a few machine status control bits, the type of a memory access and the flag bits of the leaf page-table entry that a walker has already found. From these it works out the privilege level the access runs at. It then decides whether the leaf entry allows the access, and raises a page-fault flag that matches the access type when it does not.

The block has two smaller jobs. First, it reports whether a supervisor-level access to the address-translation root register, or a translation-fence instruction, must trap as an illegal instruction because virtual-memory management is being intercepted. Second, it turns the raw two-bit previous-privilege field into a legal value, and flags when a return instruction that drops below machine mode must clear the modify-privilege control.

Two elaboration-time parameters select whether supervisor and user modes exist. Each variant of the logic is chosen by a generate block.

Top module: `xlat_priv_gate`

## Requirements
- R1: For an instruction fetch (access code 2'b00), `eff_priv` equals `cur_priv`, whatever the value of `st_mprv`.
- R2: For a load (2'b01) or a store (2'b10), `eff_priv` equals `cur_priv` when `st_mprv` is 0. When `st_mprv` is 1 it equals the legalized previous-privilege value. For access code 2'b11 (no access), `eff_priv` equals `cur_priv`. Privilege encodings are U=2'b00, S=2'b01, M=2'b11.
- R3: `mpp_legal` keeps 2'b11. It keeps 2'b00 when user mode exists and 2'b01 when supervisor mode exists. Every other encoding becomes 2'b11.
- R4: No page-fault flag is raised in these cases: `paging_on` is 0, `eff_priv` is M, or the access code is 2'b11.
- R5: A checked load faults (`load_pf`) unless R=1, or unless `st_mxr`=1 and X=1.
- R6: A checked store faults (`store_pf`) unless W=1. A checked fetch faults (`fetch_pf`) unless X=1. At most one fault flag is set.
- R7: With an effective privilege of S, a U=1 page always faults for a fetch, and faults for a load or store unless `st_sum`=1. With an effective privilege of U, a U=0 page always faults.
- R8: `illegal_instr` is 1 exactly when `cur_priv` is S, `st_tvm` is 1, and `satp_access` or `sfence_req` is 1.
- R9: `mprv_clear` is 1 exactly when `ret_fire` is 1 and `ret_target` is not M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_priv | input | 2 | Current privilege mode |
| st_mprv | input | 1 | Modify-privilege control for data accesses |
| st_mpp | input | 2 | Raw previous-privilege field |
| st_mxr | input | 1 | Make-executable-readable control |
| st_sum | input | 1 | Supervisor access to user pages permitted |
| st_tvm | input | 1 | Intercept virtual-memory management in S-mode |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 none |
| pte_r | input | 1 | Leaf entry readable |
| pte_w | input | 1 | Leaf entry writable |
| pte_x | input | 1 | Leaf entry executable |
| pte_u | input | 1 | Leaf entry user page |
| paging_on | input | 1 | Page-based translation active |
| satp_access | input | 1 | Instruction reads or writes the translation root register |
| sfence_req | input | 1 | Instruction is a translation fence |
| ret_fire | input | 1 | A trap-return instruction retires |
| ret_target | input | 2 | Privilege the return goes to |
| eff_priv | output | 2 | Privilege the access runs at |
| mpp_legal | output | 2 | Legalized previous-privilege field |
| fetch_pf | output | 1 | Instruction page fault |
| load_pf | output | 1 | Load page fault |
| store_pf | output | 1 | Store page fault |
| illegal_instr | output | 1 | Illegal-instruction trap for intercepted operations |
| mprv_clear | output | 1 | Modify-privilege control must be cleared |

## Verification
The bench sweeps every combination of privilege, modify-privilege control, raw previous-privilege value, readable-executable and supervisor-user controls, access type, leaf flags and paging state, and compares the outputs against an arithmetic model. One class of faults it catches is a design that applies the previous-privilege value to fetches, or that forgets to legalize the reserved encoding 2'b10; either would run a fetch, or a data access, at the wrong level and the fault flags would diverge. Other sweeps catch a design that lets the readable-executable control widen stores or fetches, that checks permissions in machine mode or with translation off, that lets supervisor code execute from user pages, or that traps the intercepted operations outside supervisor mode. Further sweeps over the return path catch a modify-privilege clear that wrongly fires on a return to machine mode.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
   localparam int PRIV_W = 2;
   localparam int KIND_W = 2;

   localparam logic [PRIV_W-1:0] PRV_U = 2'b00;
   localparam logic [PRIV_W-1:0] PRV_S = 2'b01;
   localparam logic [PRIV_W-1:0] PRV_M = 2'b11;

   localparam logic [KIND_W-1:0] ACC_FETCH = 2'b00;
   localparam logic [KIND_W-1:0] ACC_LOAD  = 2'b01;
   localparam logic [KIND_W-1:0] ACC_STORE = 2'b10;
   localparam logic [KIND_W-1:0] ACC_NONE  = 2'b11;

   typedef struct packed {
      logic r;
      logic w;
      logic x;
      logic u;
   } leaf_flags_t;
endpackage

// File: rtl/xpg_mpp_legal.sv
module xpg_mpp_legal
   import xpg_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1,
   parameter bit HAS_UMODE = 1'b1
) (
   input  logic [PRIV_W-1:0] raw_mpp,
   output logic [PRIV_W-1:0] legal_mpp
);
   logic s_ok;
   logic u_ok;

   generate
      if (HAS_SMODE) begin : g_s
         assign s_ok = (raw_mpp == PRV_S);
      end else begin : g_no_s
         assign s_ok = 1'b0;
      end
      if (HAS_UMODE) begin : g_u
         assign u_ok = (raw_mpp == PRV_U);
      end else begin : g_no_u
         assign u_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      if (s_ok || u_ok) legal_mpp = raw_mpp;
      else              legal_mpp = PRV_M;
   end

   always_comb begin
      // R3
      mpp_encoding_chk: assert (legal_mpp != 2'b10);
   end
endmodule

// File: rtl/xpg_eff_sel.sv
module xpg_eff_sel
   import xpg_pkg::*;
#(
   parameter bit HAS_UMODE = 1'b1
) (
   input  logic [PRIV_W-1:0] cur_priv,
   input  logic [KIND_W-1:0] kind,
   input  logic              mprv,
   input  logic [PRIV_W-1:0] mpp_ok,
   output logic [PRIV_W-1:0] eff
);
   logic is_data;
   logic use_mpp;

   assign is_data = (kind == ACC_LOAD) || (kind == ACC_STORE);

   generate
      if (HAS_UMODE) begin : g_mprv
         assign use_mpp = is_data & mprv;
      end else begin : g_mprv_tied
         assign use_mpp = 1'b0;
      end
   endgenerate

   assign eff = use_mpp ? mpp_ok : cur_priv;

   always_comb begin
      // R1
      fetch_priv_chk: assert (kind != ACC_FETCH || eff == cur_priv);
   end
endmodule

// File: rtl/xpg_leaf_chk.sv
module xpg_leaf_chk
   import xpg_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1
) (
   input  logic [PRIV_W-1:0] eff,
   input  logic [KIND_W-1:0] kind,
   input  leaf_flags_t       flg,
   input  logic              mxr,
   input  logic              sum,
   input  logic              paging,
   output logic              pf_fetch,
   output logic              pf_load,
   output logic              pf_store
);
   logic mxr_eff;
   logic sum_eff;
   logic checked;
   logic perm_ok;
   logic user_ok;
   logic deny;

   generate
      if (HAS_SMODE) begin : g_sv
         assign mxr_eff = mxr;
         assign sum_eff = sum;
      end else begin : g_no_sv
         assign mxr_eff = 1'b0;
         assign sum_eff = 1'b0;
      end
   endgenerate

   assign checked = paging && (eff != PRV_M) && (kind != ACC_NONE);

   always_comb begin
      unique case (kind)
         ACC_FETCH: perm_ok = flg.x;
         ACC_LOAD:  perm_ok = flg.r | (mxr_eff & flg.x);
         ACC_STORE: perm_ok = flg.w;
         default:   perm_ok = 1'b1;
      endcase
   end

   always_comb begin
      if (eff == PRV_S)
         user_ok = !flg.u || ((kind != ACC_FETCH) && sum_eff);
      else if (eff == PRV_U)
         user_ok = flg.u;
      else
         user_ok = 1'b1;
   end

   assign deny     = checked && !(perm_ok && user_ok);
   assign pf_fetch = deny && (kind == ACC_FETCH);
   assign pf_load  = deny && (kind == ACC_LOAD);
   assign pf_store = deny && (kind == ACC_STORE);

   always_comb begin
      // R4
      unpaged_quiet_chk: assert (paging || !(pf_fetch | pf_load | pf_store));
      // R6
      single_fault_chk: assert ($onehot0({pf_fetch, pf_load, pf_store}));
   end
endmodule

// File: rtl/xpg_vm_trap.sv
module xpg_vm_trap
   import xpg_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1
) (
   input  logic [PRIV_W-1:0] cur_priv,
   input  logic              tvm,
   input  logic              satp_op,
   input  logic              fence_op,
   output logic              trap
);
   generate
      if (HAS_SMODE) begin : g_tvm
         assign trap = tvm && (cur_priv == PRV_S) && (satp_op || fence_op);
      end else begin : g_no_tvm
         assign trap = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/xlat_priv_gate.sv
module xlat_priv_gate
   import xpg_pkg::*;
#(
   parameter bit HAS_SMODE = 1'b1,
   parameter bit HAS_UMODE = 1'b1
) (
   input  logic [1:0] cur_priv,
   input  logic       st_mprv,
   input  logic [1:0] st_mpp,
   input  logic       st_mxr,
   input  logic       st_sum,
   input  logic       st_tvm,
   input  logic [1:0] acc_kind,
   input  logic       pte_r,
   input  logic       pte_w,
   input  logic       pte_x,
   input  logic       pte_u,
   input  logic       paging_on,
   input  logic       satp_access,
   input  logic       sfence_req,
   input  logic       ret_fire,
   input  logic [1:0] ret_target,
   output logic [1:0] eff_priv,
   output logic [1:0] mpp_legal,
   output logic       fetch_pf,
   output logic       load_pf,
   output logic       store_pf,
   output logic       illegal_instr,
   output logic       mprv_clear
);
   generate
      if (HAS_SMODE && !HAS_UMODE) begin : g_bad_cfg
         $error("supervisor mode requires user mode");
      end
   endgenerate

   leaf_flags_t flg;
   assign flg = '{r: pte_r, w: pte_w, x: pte_x, u: pte_u};

   xpg_mpp_legal #(.HAS_SMODE(HAS_SMODE), .HAS_UMODE(HAS_UMODE)) u_mpp (
      .raw_mpp   (st_mpp),
      .legal_mpp (mpp_legal)
   );

   xpg_eff_sel #(.HAS_UMODE(HAS_UMODE)) u_sel (
      .cur_priv (cur_priv),
      .kind     (acc_kind),
      .mprv     (st_mprv),
      .mpp_ok   (mpp_legal),
      .eff      (eff_priv)
   );

   xpg_leaf_chk #(.HAS_SMODE(HAS_SMODE)) u_leaf (
      .eff      (eff_priv),
      .kind     (acc_kind),
      .flg      (flg),
      .mxr      (st_mxr),
      .sum      (st_sum),
      .paging   (paging_on),
      .pf_fetch (fetch_pf),
      .pf_load  (load_pf),
      .pf_store (store_pf)
   );

   xpg_vm_trap #(.HAS_SMODE(HAS_SMODE)) u_trap (
      .cur_priv (cur_priv),
      .tvm      (st_tvm),
      .satp_op  (satp_access),
      .fence_op (sfence_req),
      .trap     (illegal_instr)
   );

   assign mprv_clear = ret_fire && (ret_target != PRV_M);

   always_comb begin
      // R4
      mach_quiet_chk: assert (eff_priv != PRV_M || !(fetch_pf | load_pf | store_pf));
      // R8
      tvm_scope_chk: assert (!illegal_instr || (cur_priv == PRV_S && st_tvm));
      // R9
      ret_clear_chk: assert (!mprv_clear || ret_fire);
      // R2
      data_priv_chk: assert (st_mprv || eff_priv == cur_priv);
   end
endmodule

// File: tb/sim_xlat_priv_gate.sv
`timescale 1ns/100ps
module sim_xlat_priv_gate;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0] cur_priv, st_mpp, acc_kind, ret_target;
   logic st_mprv, st_mxr, st_sum, st_tvm;
   logic pte_r, pte_w, pte_x, pte_u, paging_on, satp_access, sfence_req, ret_fire;
   logic [1:0] eff_priv, mpp_legal;
   logic fetch_pf, load_pf, store_pf, illegal_instr, mprv_clear;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   xlat_priv_gate u0 (.*);

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int legal_of(input int m);
      return (m == 1 || m == 0) ? m : 3;
   endfunction

   initial begin
      cur_priv = 0; st_mpp = 0; acc_kind = 0; ret_target = 0;
      st_mprv = 0; st_mxr = 0; st_sum = 0; st_tvm = 0;
      pte_r = 0; pte_w = 0; pte_x = 0; pte_u = 0; paging_on = 0;
      satp_access = 0; sfence_req = 0; ret_fire = 0;
      @(negedge clk); #1;
      // reset-state style check with all inputs low
      chk("R1 idle eff", eff_priv, 0);
      chk("R4 idle pf", {fetch_pf, load_pf, store_pf}, 0);
      chk("R8 idle ill", illegal_instr, 0);
      chk("R9 idle clr", mprv_clear, 0);

      for (int cp = 0; cp < 3; cp++)
      for (int mp = 0; mp < 2; mp++)
      for (int pp = 0; pp < 4; pp++)
      for (int mx = 0; mx < 2; mx++)
      for (int sm = 0; sm < 2; sm++)
      for (int kd = 0; kd < 4; kd++)
      for (int fl = 0; fl < 16; fl++)
      for (int pg = 0; pg < 2; pg++) begin
         int cpv, e, ok_p, ok_u, chkd, f;
         int r, w, x, u;
         string tg;
         cpv = (cp == 2) ? 3 : cp;
         r = (fl >> 3) & 1; w = (fl >> 2) & 1; x = (fl >> 1) & 1; u = fl & 1;
         @(negedge clk);
         cur_priv = 2'(cpv); st_mprv = mp[0]; st_mpp = 2'(pp); st_mxr = mx[0];
         st_sum = sm[0]; acc_kind = 2'(kd); pte_r = r[0]; pte_w = w[0];
         pte_x = x[0]; pte_u = u[0]; paging_on = pg[0];
         #1;
         e = ((kd == 1 || kd == 2) && mp == 1) ? legal_of(pp) : cpv;
         chk(kd == 0 ? "R1 eff" : "R2 eff", eff_priv, e);
         chk("R3 mpp", mpp_legal, legal_of(pp));
         chkd = (pg == 1 && e != 3 && kd != 3);
         ok_p = (kd == 0) ? x : (kd == 1) ? (r | (mx & x)) : (kd == 2) ? w : 1;
         if (e == 1) ok_u = (u == 0) || (kd != 0 && sm == 1);
         else if (e == 0) ok_u = u;
         else ok_u = 1;
         f = chkd && !(ok_p && ok_u);
         if (!chkd) tg = "R4";
         else if (!ok_u) tg = "R7";
         else if (kd == 1) tg = "R5";
         else tg = "R6";
         chk({tg, " fetch_pf"}, fetch_pf, (kd == 0) ? f : 0);
         chk({tg, " load_pf"},  load_pf,  (kd == 1) ? f : 0);
         chk({tg, " store_pf"}, store_pf, (kd == 2) ? f : 0);
      end

      for (int cp = 0; cp < 4; cp++)
      for (int tv = 0; tv < 2; tv++)
      for (int sa = 0; sa < 2; sa++)
      for (int sf = 0; sf < 2; sf++) begin
         @(negedge clk);
         cur_priv = 2'(cp); st_tvm = tv[0]; satp_access = sa[0]; sfence_req = sf[0];
         #1;
         chk("R8 illegal", illegal_instr, (cp == 1 && tv == 1 && (sa | sf)) ? 1 : 0);
      end

      for (int rf = 0; rf < 2; rf++)
      for (int rt = 0; rt < 4; rt++) begin
         @(negedge clk);
         ret_fire = rf[0]; ret_target = 2'(rt);
         #1;
         chk("R9 clear", mprv_clear, (rf == 1 && rt != 3) ? 1 : 0);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule